// File: doc/BRIEF.md
# Header/Footer Byte Stream Deframer

This block sits behind a serial byte receiver and turns an unframed 8-bit byte stream into packets with an end marker on the output bus. In the incoming stream a packet begins with the opening code 0xFF and ends with the closing code 0xF1. Every byte between the two is payload, and payload values are always in the range 0x00 to 0x7F, so they can never be mistaken for either code. The output is an 8-bit valid/ready stream that carries the payload bytes only, with a last-beat flag raised on the final payload byte of each packet.

A payload byte cannot be labelled until the next byte has arrived, because only that byte shows whether it was the last one. The block therefore keeps the most recent payload byte in a one-entry hold register. It releases that byte to a one-entry output register when the next payload byte is accepted (last flag low) or when the closing code is accepted (last flag high). Both interfaces apply valid/ready flow control. The input is stalled only when a held byte has to move on and the output register is still occupied by a beat the consumer has not taken.

Top module: `frame_unpacker`

## Requirements
- R1: While a packet is open, every input byte other than 0xFF and 0xF1 is payload. Payload bytes reach the output in arrival order, each exactly once, and the codes 0xFF and 0xF1 never appear on the output.
- R2: The output last flag is 1 on the final payload byte of a packet (the byte followed by 0xF1) and 0 on every other output beat.
- R3: The input sequence 0xFF, d, 0xF1 produces exactly one output beat, with data d and the last flag at 1.
- R4: A closing code 0xF1 that directly follows the opening code 0xFF produces no output beat.
- R5: Any byte accepted while no packet is open, other than 0xFF, is discarded and produces no output.
- R6: After reset no packet is open, the hold register is empty, out_valid is 0 and in_ready is 1.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data and out_last do not change on the next cycle.
- R8: in_ready is 0 only while out_valid is 1 and out_ready is 0. Under any pattern of backpressure on either side, no byte is lost or duplicated.
- R9: Packet length has no limit. A packet of several hundred payload bytes comes out complete, with a single last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| aresetn | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Incoming byte |
| in_valid | input | 1 | Incoming byte is valid |
| in_ready | output | 1 | Block accepts the incoming byte |
| out_data | output | 8 | Payload byte |
| out_valid | output | 1 | Payload byte is valid |
| out_last | output | 1 | Final payload byte of the packet |
| out_ready | input | 1 | Consumer accepts the payload byte |

## Verification
A packet-open flag stuck in the wrong state shows up at the ports within one packet. Noise bytes then leak out as payload, or a whole packet disappears, and the scoreboard reports it on the next output beat. A hold register that loses or repeats its content under backpressure produces a wrong byte or a wrong last flag one beat after the stall ends. An output register that changes while stalled is reported on the very next cycle, both by the stability check and by the bound property. Randomised valid/ready duty cycles reach the case where the hold register and the output register are both full at the same time, which is the only point where the input is stalled.

// File: rtl/fu_pkg.sv
package fu_pkg;

    typedef enum logic [1:0] {
        KIND_OPEN  = 2'd0,
        KIND_CLOSE = 2'd1,
        KIND_DATA  = 2'd2
    } byte_kind_e;

endpackage

// File: rtl/fu_classify.sv
module fu_classify
    import fu_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter logic [DATA_W-1:0] OPEN_CODE  = 8'hFF,
    parameter logic [DATA_W-1:0] CLOSE_CODE = 8'hF1
) (
    input  logic [DATA_W-1:0] byte_i,
    output byte_kind_e        kind_o
);

    always_comb begin
        if (byte_i == OPEN_CODE) begin
            kind_o = KIND_OPEN;
        end else if (byte_i == CLOSE_CODE) begin
            kind_o = KIND_CLOSE;
        end else begin
            kind_o = KIND_DATA;
        end
    end

endmodule

// File: rtl/fu_framer.sv
module fu_framer
    import fu_pkg::*;
(
    input  logic       clk,
    input  logic       aresetn,
    input  logic       in_valid,
    input  byte_kind_e kind,
    input  logic       hold_vld,
    input  logic       out_free,
    output logic       in_ready,
    output logic       load_hold,
    output logic       clr_hold,
    output logic       push,
    output logic       push_last
);

    typedef struct packed {
        logic open;
    } frm_state_t;

    frm_state_t st_d, st_q;
    logic       accept;

    // Stall only when the held byte must move and the output slot is busy.
    assign in_ready = !st_q.open || !hold_vld || out_free;
    assign accept   = in_valid && in_ready;

    always_comb begin
        st_d      = st_q;
        load_hold = 1'b0;
        clr_hold  = 1'b0;
        push      = 1'b0;
        push_last = 1'b0;
        if (accept) begin
            unique case (kind)
                KIND_OPEN: begin
                    if (!st_q.open) begin
                        st_d.open = 1'b1;
                    end
                end
                KIND_CLOSE: begin
                    if (st_q.open) begin
                        st_d.open = 1'b0;
                        if (hold_vld) begin
                            push      = 1'b1;
                            push_last = 1'b1;
                            clr_hold  = 1'b1;
                        end
                    end
                end
                default: begin
                    if (st_q.open) begin
                        load_hold = 1'b1;
                        push      = hold_vld;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge aresetn) begin
        if (!aresetn) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fu_hold.sv
module fu_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              aresetn,
    input  logic              load,
    input  logic              clr,
    input  logic [DATA_W-1:0] load_data,
    output logic              vld,
    output logic [DATA_W-1:0] data
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (load) begin
            h_d.vld  = 1'b1;
            h_d.data = load_data;
        end else if (clr) begin
            h_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge aresetn) begin
        if (!aresetn) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign vld  = h_q.vld;
    assign data = h_q.data;

endmodule

// File: rtl/fu_outreg.sv
module fu_outreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              aresetn,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_last,
    input  logic              ready,
    output logic              free,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    output logic              last
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
        logic              last;
    } oreg_t;

    oreg_t o_d, o_q;

    assign free = !o_q.vld || ready;

    always_comb begin
        o_d = o_q;
        if (push) begin
            o_d.vld  = 1'b1;
            o_d.data = push_data;
            o_d.last = push_last;
        end else if (ready) begin
            o_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge aresetn) begin
        if (!aresetn) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign valid = o_q.vld;
    assign data  = o_q.data;
    assign last  = o_q.last;

endmodule

// File: rtl/frame_unpacker.sv
module frame_unpacker
    import fu_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter logic [DATA_W-1:0] OPEN_CODE  = 8'hFF,
    parameter logic [DATA_W-1:0] CLOSE_CODE = 8'hF1
) (
    input  logic              clk,
    input  logic              aresetn,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_last,
    input  logic              out_ready
);

    byte_kind_e        kind;
    logic              hold_vld;
    logic [DATA_W-1:0] hold_data;
    logic              out_free;
    logic              load_hold;
    logic              clr_hold;
    logic              push;
    logic              push_last;

    fu_classify #(
        .DATA_W    (DATA_W),
        .OPEN_CODE (OPEN_CODE),
        .CLOSE_CODE(CLOSE_CODE)
    ) u_classify (
        .byte_i(in_data),
        .kind_o(kind)
    );

    fu_framer u_framer (
        .clk      (clk),
        .aresetn  (aresetn),
        .in_valid (in_valid),
        .kind     (kind),
        .hold_vld (hold_vld),
        .out_free (out_free),
        .in_ready (in_ready),
        .load_hold(load_hold),
        .clr_hold (clr_hold),
        .push     (push),
        .push_last(push_last)
    );

    fu_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .aresetn  (aresetn),
        .load     (load_hold),
        .clr      (clr_hold),
        .load_data(in_data),
        .vld      (hold_vld),
        .data     (hold_data)
    );

    fu_outreg #(.DATA_W(DATA_W)) u_outreg (
        .clk      (clk),
        .aresetn  (aresetn),
        .push     (push),
        .push_data(hold_data),
        .push_last(push_last),
        .ready    (out_ready),
        .free     (out_free),
        .valid    (out_valid),
        .data     (out_data),
        .last     (out_last)
    );

endmodule

// File: rtl/fu_checker.sv
module fu_checker #(
    parameter int          DATA_W     = 8,
    parameter logic [DATA_W-1:0] OPEN_CODE  = 8'hFF,
    parameter logic [DATA_W-1:0] CLOSE_CODE = 8'hF1
) (
    input logic              clk,
    input logic              aresetn,
    input logic [DATA_W-1:0] in_data,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_last,
    input logic              out_ready
);

    logic up_q;

    always_ff @(posedge clk or negedge aresetn) begin
        if (!aresetn) begin
            up_q <= 1'b0;
        end else begin
            up_q <= 1'b1;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!aresetn)
        !up_q |-> (!out_valid && in_ready)); // R6

    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!aresetn)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R7

    AST_READY_ONLY_STALL: assert property (@(posedge clk) disable iff (!aresetn)
        !in_ready |-> (out_valid && !out_ready)); // R8

    AST_NO_CODES_OUT: assert property (@(posedge clk) disable iff (!aresetn)
        out_valid |-> (out_data != OPEN_CODE && out_data != CLOSE_CODE)); // R1

    AST_LAST_FROM_CLOSE: assert property (@(posedge clk) disable iff (!aresetn)
        (up_q && out_valid && out_last && !$past(out_valid && !out_ready))
        |-> $past(in_valid && in_ready && in_data == CLOSE_CODE)); // R2

    AST_BODY_FROM_DATA: assert property (@(posedge clk) disable iff (!aresetn)
        (up_q && out_valid && !out_last && !$past(out_valid && !out_ready))
        |-> $past(in_valid && in_ready && in_data != CLOSE_CODE && in_data != OPEN_CODE)); // R1

endmodule

bind frame_unpacker fu_checker #(
    .DATA_W    (DATA_W),
    .OPEN_CODE (OPEN_CODE),
    .CLOSE_CODE(CLOSE_CODE)
) u_chk (
    .clk      (clk),
    .aresetn  (aresetn),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_data (out_data),
    .out_valid(out_valid),
    .out_last (out_last),
    .out_ready(out_ready)
);

// File: tb/frame_unpacker_test.sv
`timescale 1ns/100ps
module frame_unpacker_test;

    localparam logic [7:0] OPEN_B  = 8'hFF;
    localparam logic [7:0] CLOSE_B = 8'hF1;

    logic       clk = 1'b0;
    logic       aresetn;
    logic [7:0] in_data;
    logic       in_valid;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_last;
    logic       out_ready;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    logic [7:0] stim[$];
    logic [7:0] exp_d[$];
    logic       exp_l[$];
    string      exp_t[$];
    string      cur_tag;
    int         phase_beats;

    bit         m_open = 1'b0;
    bit         m_hv   = 1'b0;
    logic [7:0] m_hd   = 8'h00;

    always #2.5 clk = ~clk;

    frame_unpacker uut (
        .clk      (clk),
        .aresetn  (aresetn),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .out_data (out_data),
        .out_valid(out_valid),
        .out_last (out_last),
        .out_ready(out_ready)
    );

    task automatic fail(string tag, string what, int act, int expv);
        nerr++;
        $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    endtask

    task automatic check(string tag, string what, int act, int expv);
        nchk++;
        if (act != expv) fail(tag, what, act, expv);
    endtask

    // Reference model of the framing rules, fed in stream order.
    task automatic model_byte(logic [7:0] b);
        if (!m_open) begin
            if (b == OPEN_B) m_open = 1'b1;
        end else if (b == CLOSE_B) begin
            m_open = 1'b0;
            if (m_hv) begin
                exp_d.push_back(m_hd); exp_l.push_back(1'b1); exp_t.push_back(cur_tag);
                m_hv = 1'b0;
            end
        end else if (b != OPEN_B) begin
            if (m_hv) begin
                exp_d.push_back(m_hd); exp_l.push_back(1'b0); exp_t.push_back(cur_tag);
            end
            m_hd = b;
            m_hv = 1'b1;
        end
    endtask

    task automatic put(logic [7:0] b);
        stim.push_back(b);
        model_byte(b);
    endtask

    function automatic logic [7:0] noise_byte();
        return 8'h80 + 8'($urandom % 127);
    endfunction

    task automatic gen_packet(int len, int max_noise);
        int nn = (max_noise > 0) ? int'($urandom % (max_noise + 1)) : 0;
        for (int i = 0; i < nn; i++) put(noise_byte());
        put(OPEN_B);
        for (int i = 0; i < len; i++) put(8'($urandom % 128));
        put(CLOSE_B);
    endtask

    task automatic run_stream(int pv, int pr);
        int   guard = 0;
        bit   vhold = 1'b0;
        bit   prev_stall = 1'b0;
        logic [7:0] pd = 8'h00;
        logic pl = 1'b0;
        phase_beats = 0;
        while ((stim.size() > 0 || exp_d.size() > 0) && guard < 50000) begin
            @(negedge clk);
            in_valid  = (stim.size() > 0) && (vhold || (int'($urandom % 100) < pv));
            in_data   = (stim.size() > 0) ? stim[0] : 8'h00;
            out_ready = int'($urandom % 100) < pr;
            #1;
            if (prev_stall) begin
                nchk++;
                if (!(out_valid && out_data == pd && out_last == pl))
                    fail("R7", "stalled beat changed", {out_valid, out_last, out_data}, {1'b1, pl, pd});
            end
            if (!in_ready) begin
                nchk++;
                if (!(out_valid && !out_ready))
                    fail("R8", "input stalled without output stall", {out_valid, out_ready}, 2'b10);
            end
            if (out_valid && out_ready) begin
                phase_beats++;
                if (exp_d.size() == 0) begin
                    fail(cur_tag, "unexpected output beat", out_data, -1);
                end else begin
                    check(exp_t[0], "payload byte", out_data, exp_d[0]);
                    check("R2", "last flag", out_last, exp_l[0]);
                    void'(exp_d.pop_front()); void'(exp_l.pop_front()); void'(exp_t.pop_front());
                end
            end
            if (in_valid && in_ready) void'(stim.pop_front());
            vhold      = in_valid && !in_ready;
            prev_stall = out_valid && !out_ready;
            pd         = out_data;
            pl         = out_last;
            guard++;
        end
        if (guard >= 50000) fail(cur_tag, "stream did not drain", stim.size() + exp_d.size(), 0);
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(cur_tag, "output idle after drain", out_valid, 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        aresetn   = 1'b0;
        in_valid  = 1'b0;
        in_data   = 8'h00;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R6", "out_valid in reset", out_valid, 0);
        aresetn = 1'b1;
        @(negedge clk);
        #1;
        check("R6", "out_valid after reset", out_valid, 0);
        check("R6", "in_ready after reset", in_ready, 1);

        // R3: single-byte packet
        cur_tag = "R3";
        put(OPEN_B); put(8'h05); put(CLOSE_B);
        run_stream(100, 100);
        check("R3", "beats for single-byte packet", phase_beats, 1);

        // R4: empty packets
        cur_tag = "R4";
        put(OPEN_B); put(CLOSE_B); put(OPEN_B); put(CLOSE_B);
        run_stream(100, 100);
        check("R4", "beats for empty packets", phase_beats, 0);

        // R5: noise outside packets, then one real packet
        cur_tag = "R5";
        put(8'h33); put(8'h7E); put(CLOSE_B); put(8'h90);
        put(OPEN_B); put(8'h11); put(8'h22); put(CLOSE_B);
        put(8'h01); put(CLOSE_B);
        run_stream(100, 100);
        check("R5", "beats with noise around packet", phase_beats, 2);

        // R1: random packets, light backpressure
        cur_tag = "R1";
        for (int p = 0; p < 30; p++) gen_packet(1 + int'($urandom % 12), 2);
        run_stream(70, 80);

        // R8: random packets, heavy output backpressure
        cur_tag = "R8";
        for (int p = 0; p < 30; p++) gen_packet(1 + int'($urandom % 12), 2);
        run_stream(90, 30);

        // R9: one long packet
        cur_tag = "R9";
        gen_packet(300, 0);
        run_stream(100, 60);
        check("R9", "beats for long packet", phase_beats, 300);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule